// File: doc/BRIEF.md
# Extended Microsecond Timestamp Counter

This block keeps a 32-bit microsecond timestamp on a chip that runs from a fast system clock. A prescaler divides the system clock down to one tick per microsecond. The ticks drive a 24-bit minor counter that runs through a fixed period and then starts over. Each time the minor counter completes a period it raises a wrap flag. After a fixed service latency, the block advances a 32-bit major count and drops the flag. Until that happens, the flag stands for a pending carry.

A reader pulses `rd_req` to get a timestamp. The block samples the minor count first and the wrap flag, major count and compensation one clock later. It then combines them into `(major + pending) * period + minor + compensation`. There is one special case: a pending flag combined with a minor count above half the period means the sample was taken just before the wrap. In that case the result is `(major + 1) * period + compensation` and the minor count is not used. A minor sample equal to 0 or to the full period is refused and taken again one clock later. On each wake-up event, the sleep duration presented on `wake_us` is added into a compensation accumulator. All sums wrap modulo 2^32.

Top module: `usec_timestamp`

## Requirements
- R1: The minor counter advances once every DIV+1 clocks. DIV is CLK_HZ/1,000,000 - 1, clamped to the range 0..127.
- R2: After reset the minor count is 0. On each tick it steps by one up to the period P, and the tick after P loads 1. P is PERIOD_US clamped to the range 2..0xFFFFFF.
- R3: `wrap_flag` rises on the tick that brings the minor count to P and stays high for SVC_LAT clocks. The major count increments on the same edge where the flag falls.
- R4: When `rd_req` is high while the reader is idle, that edge samples the minor count. The next edge samples the flag, the major count and the compensation. `read_valid` then pulses high for exactly one cycle, carrying `read_ts`.
- R5: The result is `(major + flag) * P + minor + comp`, taken modulo 2^32.
- R6: If the flag is high and the sampled minor count is above P/2, the result is `(major + 1) * P + comp`.
- R7: A minor sample of 0 or of P produces no result. The minor count is sampled again on the next edge, and the check repeats until a sample is accepted.
- R8: Each cycle with `wake_valid` high adds `wake_us` into the compensation, modulo 2^32.
- R9: `rd_req` has no effect while a read is in progress.
- R10: A synchronous reset clears the prescaler, the minor and major counts, the flag, the compensation and the reader. `read_valid` and `wrap_flag` are low after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| rd_req | input | 1 | Request a timestamp read |
| wake_valid | input | 1 | Add `wake_us` to the compensation this cycle |
| wake_us | input | 32 | Duration of the sleep just ended, in microseconds |
| read_valid | output | 1 | One-cycle pulse marking `read_ts` as a fresh result |
| read_ts | output | 32 | Combined microsecond timestamp |
| wrap_flag | output | 1 | Pending-carry flag of the minor counter |

## Verification
The bench targets read edges around each wrap, because that is where a wrong combining rule shows up.

- The first targeted read has its minor sample taken on the very edge where the flag rises. A design that ignores the half-period rule returns a value almost a whole period too high.
- A second targeted read samples a minor count of exactly P. A design without resampling reports that sample, one full period ahead once the major count has moved.
- Holding `rd_req` high through the pending window mixes post-wrap samples with the pending flag. A design that drops the carry returns a value one period low.
- Sampling the flag before the minor count also gives a value one period low.
- Reads right after reset see a minor count of 0. A design without the retry reports them instead of waiting.
- Wake amounts that overflow 32 bits check that the compensation wraps instead of saturating.

// File: rtl/usec_timestamp.sv
module usec_timestamp #(
  parameter int unsigned CLK_HZ    = 8_000_000,
  parameter int unsigned PERIOD_US = 10_000_000,
  parameter int unsigned SVC_LAT   = 16
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        rd_req,
  input  logic        wake_valid,
  input  logic [31:0] wake_us,
  output logic        read_valid,
  output logic [31:0] read_ts,
  output logic        wrap_flag
);
  localparam int unsigned DIV_RAW = (CLK_HZ / 1_000_000 == 0) ? 0 : CLK_HZ / 1_000_000 - 1;
  localparam int unsigned DIV     = (DIV_RAW > 127) ? 127 : DIV_RAW;
  localparam int unsigned CMP_LO  = (PERIOD_US < 2) ? 2 : PERIOD_US;
  localparam int unsigned CMP     = (CMP_LO > 32'hFF_FFFF) ? 32'hFF_FFFF : CMP_LO;
  localparam int unsigned LAT     = (SVC_LAT < 1) ? 1 : SVC_LAT;
  localparam int PSC_W = 7;
  localparam int MIN_W = 24;
  localparam int SVC_W = $clog2(LAT + 1);
  localparam logic [PSC_W-1:0] DIV_V    = PSC_W'(DIV);
  localparam logic [MIN_W-1:0] CMP_V    = MIN_W'(CMP);
  localparam logic [MIN_W-1:0] CMP_M1   = MIN_W'(CMP - 1);
  localparam logic [MIN_W-1:0] HALF_V   = MIN_W'(CMP / 2);
  localparam logic [31:0]      CMP_32   = 32'(CMP);
  localparam logic [SVC_W-1:0] LAT_LAST = SVC_W'(LAT - 1);

  typedef enum logic [0:0] {RD_IDLE, RD_FLAG} rd_state_e;

  logic [PSC_W-1:0] pre_cnt;
  logic [MIN_W-1:0] minor;
  logic [31:0]      major;
  logic [31:0]      comp;
  logic [SVC_W-1:0] svc_cnt;
  logic [MIN_W-1:0] min_q;
  rd_state_e        rd_st;
  logic [31:0]      ts_next;

  wire tick    = (pre_cnt == DIV_V);
  wire min_bad = (min_q == '0) || (min_q == CMP_V);

  always_ff @(posedge clk) begin
    if (rst) pre_cnt <= '0;
    else     pre_cnt <= tick ? '0 : pre_cnt + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst)       minor <= '0;
    else if (tick) minor <= (minor == CMP_V) ? MIN_W'(1) : minor + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wrap_flag <= 1'b0;
      svc_cnt   <= '0;
      major     <= '0;
    end else if (wrap_flag) begin
      if (svc_cnt == LAT_LAST) begin
        wrap_flag <= 1'b0;
        svc_cnt   <= '0;
        major     <= major + 1'b1;
      end else begin
        svc_cnt <= svc_cnt + 1'b1;
      end
    end else if (tick && minor == CMP_M1) begin
      wrap_flag <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)             comp <= '0;
    else if (wake_valid) comp <= comp + wake_us;
  end

  always_comb begin
    if (wrap_flag && min_q > HALF_V)
      ts_next = (major + 32'd1) * CMP_32 + comp;
    else
      ts_next = (major + {31'b0, wrap_flag}) * CMP_32 + {8'b0, min_q} + comp;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_st      <= RD_IDLE;
      min_q      <= '0;
      read_valid <= 1'b0;
      read_ts    <= '0;
    end else begin
      read_valid <= 1'b0;
      case (rd_st)
        RD_IDLE: if (rd_req) begin
          min_q <= minor;
          rd_st <= RD_FLAG;
        end
        RD_FLAG: if (min_bad) begin
          min_q <= minor;
        end else begin
          read_ts    <= ts_next;
          read_valid <= 1'b1;
          rd_st      <= RD_IDLE;
        end
        default: rd_st <= RD_IDLE;
      endcase
    end
  end
endmodule

module usec_timestamp_chk #(
  parameter int unsigned CMP = 2
) (
  input logic        clk,
  input logic        rst,
  input logic        read_valid,
  input logic        wrap_flag,
  input logic        wake_valid,
  input logic [31:0] wake_us,
  input logic [23:0] minor,
  input logic [31:0] major,
  input logic [31:0] comp,
  input logic        in_flag_state,
  input logic        min_bad
);
  localparam logic [23:0] CMP_V = 24'(CMP);

  AST_VALID_PULSE: assert property (@(posedge clk) disable iff (rst)
    read_valid |=> !read_valid); // R4

  AST_MAJOR_ON_CLEAR: assert property (@(posedge clk) disable iff (rst)
    ($past(!rst) && $fell(wrap_flag)) |-> (major == $past(major) + 32'd1)); // R3

  AST_MINOR_STEP: assert property (@(posedge clk) disable iff (rst)
    ($past(!rst) && minor != $past(minor)) |->
      ((minor == $past(minor) + 24'd1) || (minor == 24'd1 && $past(minor) == CMP_V))); // R2

  AST_RESAMPLE_NO_VALID: assert property (@(posedge clk) disable iff (rst)
    (in_flag_state && min_bad) |=> !read_valid); // R7

  AST_COMP_ADD: assert property (@(posedge clk) disable iff (rst)
    ($past(!rst) && $past(wake_valid)) |-> (comp == $past(comp) + $past(wake_us))); // R8

  AST_RESET_STATE: assert property (@(posedge clk)
    $past(rst) |-> (!read_valid && !wrap_flag && minor == 24'd0 && comp == 32'd0)); // R10
endmodule

bind usec_timestamp usec_timestamp_chk #(.CMP(CMP)) u_chk (
  .clk(clk), .rst(rst), .read_valid(read_valid), .wrap_flag(wrap_flag),
  .wake_valid(wake_valid), .wake_us(wake_us), .minor(minor), .major(major),
  .comp(comp), .in_flag_state(rd_st == RD_FLAG), .min_bad(min_bad)
);

// File: tb/tb_usec_timestamp.sv
`timescale 1ns/1ps
module tb_usec_timestamp;
  localparam int B_CLK = 2_000_000;
  localparam int B_PER = 1000;
  localparam int B_LAT = 20;
  localparam int PSC_M = B_CLK / 1_000_000 - 1;
  localparam int W     = B_PER * (PSC_M + 1);
  localparam int HALF  = B_PER / 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic rd_req = 1'b0;
  logic wake_valid = 1'b0;
  logic [31:0] wake_us = '0;
  logic read_valid, wrap_flag;
  logic [31:0] read_ts;

  usec_timestamp #(.CLK_HZ(B_CLK), .PERIOD_US(B_PER), .SVC_LAT(B_LAT)) dut (
    .clk(clk), .rst(rst), .rd_req(rd_req), .wake_valid(wake_valid), .wake_us(wake_us),
    .read_valid(read_valid), .read_ts(read_ts), .wrap_flag(wrap_flag));

  always #4 clk = ~clk;

  int vec = 0, fails = 0;
  bit done = 0, started = 0;

  // reference state: e = clock edges since reset release
  int e = 0;
  logic [31:0] comp_m = '0, exp_ts = '0, mq = '0;
  bit busy = 0, resampled = 0, exp_valid = 0, exp_flag = 0;
  string tag = "R5";

  function automatic int m_minor(int n);
    int t = n / (PSC_M + 1);
    return (t == 0) ? 0 : ((t - 1) % B_PER) + 1;
  endfunction
  function automatic bit m_pend(int n);
    return (n >= W) && ((n % W) < B_LAT);
  endfunction
  function automatic int m_major(int n);
    return (n < B_LAT) ? 0 : (n - B_LAT) / W;
  endfunction

  always @(posedge clk) begin
    logic [31:0] mn, mj;
    bit pd;
    started = 1;
    if (rst) begin
      e = 0; comp_m = '0; busy = 0; resampled = 0; exp_valid = 0;
    end else begin
      mn = 32'(m_minor(e)); pd = m_pend(e); mj = 32'(m_major(e));
      exp_valid = 0;
      if (!busy) begin
        if (rd_req) begin mq = mn; busy = 1; resampled = 0; end
      end else if (mq == 0 || mq == B_PER) begin
        mq = mn; resampled = 1;
      end else begin
        if (pd && mq > HALF) begin
          exp_ts = (mj + 1) * B_PER + comp_m; tag = "R6";
        end else begin
          exp_ts = (mj + {31'b0, pd}) * B_PER + mq + comp_m;
          tag = resampled ? "R7" : (comp_m != 0 ? "R8" : "R1 R2 R5");
        end
        exp_valid = 1; busy = 0;
      end
      if (wake_valid) comp_m = comp_m + wake_us;
      e = e + 1;
    end
    exp_flag = m_pend(e);
  end

  always @(negedge clk) if (started && !done) begin
    vec++;
    if (read_valid !== exp_valid) begin
      fails++; $display("FAIL R4 R9: read_valid actual %b expected %b at e=%0d", read_valid, exp_valid, e);
    end else if (exp_valid && read_ts !== exp_ts) begin
      fails++; $display("FAIL %s: read_ts actual %0d expected %0d at e=%0d", tag, read_ts, exp_ts, e);
    end
    if (wrap_flag !== exp_flag) begin
      fails++; $display("FAIL R3: wrap_flag actual %b expected %b at e=%0d", wrap_flag, exp_flag, e);
    end
  end

  task automatic cycles(int n);
    repeat (n) @(negedge clk);
  endtask
  task automatic pulse_read();
    rd_req = 1'b1; @(negedge clk); rd_req = 1'b0;
  endtask
  task automatic wait_e(int target);
    while (e < target) @(negedge clk);
  endtask
  task automatic do_reset();
    rst = 1'b1; rd_req = 1'b0; wake_valid = 1'b0;
    cycles(3);
    vec++;
    if (read_valid !== 1'b0 || wrap_flag !== 1'b0) begin
      fails++; $display("FAIL R10: valid/flag actual %b%b expected 00", read_valid, wrap_flag);
    end
    rst = 1'b0;
  endtask

  initial begin
    logic [15:0] lf = 16'hACE1;
    int k;
    @(negedge clk);
    do_reset();
    pulse_read();            // R7: minor still 0, resampled
    cycles(8);
    // R1 R2 R5: sparse reads at varied phases
    for (int i = 0; i < 400; i++) begin
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      pulse_read();
      if (i % 97 == 5) begin // R8: compensation, incl. 32-bit overflow
        wake_valid = 1'b1; wake_us = (i % 2 == 0) ? 32'hFFFF_FF00 : 32'd12345;
        @(negedge clk); wake_valid = 1'b0;
      end
      cycles(int'(lf[3:0]) + 3);
    end
    // R9 R3 R5: rd_req held through wrap and pending window
    for (int j = 0; j < 3; j++) begin
      k = e / W + 1;
      wait_e(k * W - 12);
      rd_req = 1'b1; cycles(50 + j); rd_req = 1'b0;
    end
    // R6: minor sampled on the edge where the flag rises
    for (int j = 0; j < 2; j++) begin
      k = e / W + 1;
      wait_e(k * W - 1);
      pulse_read(); cycles(10);
    end
    // R7: minor sampled while it equals the period
    k = e / W + 1;
    wait_e(k * W);
    pulse_read(); cycles(10);
    // R10: reset in mid-run, then reads from the fresh state
    do_reset();
    pulse_read(); cycles(6);
    for (int i = 0; i < 100; i++) begin pulse_read(); cycles(i % 7 + 2); end
    k = e / W + 1;
    wait_e(k * W - 1);
    pulse_read(); cycles(30);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vec, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1; fails++;
      $display("FAIL watchdog: run did not finish, actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vec, fails);
      $finish;
    end
  end
endmodule